// File: doc/BRIEF.md
# Push-pull digital PWM controller

This block is a clocked pulse-width modulator for a two-phase push-pull power stage. A programmable counter sets the switching period in clock cycles. A requested on-time, given in cycles, takes the place of an analog error signal. Each period can produce at most one pulse. Successive periods steer their pulse to drive A and drive B in turn, so each drive switches at half the period rate. The final cycles of every period are a forced blanking window in which neither drive may be on.

Three active-low control inputs steer the block. The resync input restarts the period on its falling edge, which lets the modulator lock to an external clock running somewhat faster than its free-running rate. The halt input suppresses every pulse, including one already in progress. The soft-start input clears the duty ramp while it is held low. After release, the ramp opens the allowed on-time gradually. A current-limit input cuts the present pulse short and keeps the drives off until the next period begins. Resync and halt are asynchronous and pass through two-flop synchronizers. The other inputs are synchronous to `clk`.

Top module: `pp_pwm`

## Requirements
- R1: The period counter runs from 0 to `period_len`, so one period lasts `period_len`+1 cycles. The phase selects drive A (phase value 0) and drive B (phase value 1) in alternate periods. Each drive therefore rises once every 2×(`period_len`+1) cycles, and drive B rises `period_len`+1 cycles after drive A.
- R2: A pulse starts at count 0 and lasts W cycles. W is the smallest of `duty_req`, the soft-start ramp and `period_len`+1−`dead_len`. W is 0 when `dead_len` exceeds `period_len`+1. The last `dead_len` counts of every period never drive an output. Each drive follows the counter with one register of delay.
- R3: `drv_a` and `drv_b` are never high in the same cycle.
- R4: While `ss_rst_n` is low, both drives stay low, the counter is held at 0, the phase is held at drive A, and the ramp is reloaded to `SS_STEP`. Each period boundary after release raises the ramp by `SS_STEP`, saturating at 2^CW−1. The first pulse after release is therefore on drive A and is `SS_STEP` cycles wide.
- R5: A falling edge on `resync_n`, seen after its two-flop synchronizer, ends the current period and starts the next one with the other drive. Holding `resync_n` low has no further effect, so the free-running period resumes.
- R6: A low level on `halt_n` forces both drives low from the third rising clock edge after the pin falls, and keeps them low for as long as it stays low. The counter keeps running. Normal pulses return once `halt_n` is high again.
- R7: When `ilim` is high at a clock edge, both drives are low after that edge. A latch then keeps them off until the next period boundary, so the next period pulses normally.
- R8: A low `rst_n` clears all state asynchronously and keeps both drives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ss_rst_n | input | 1 | Active-low soft-start reset, synchronous |
| resync_n | input | 1 | Active-low period restart, asynchronous, acts on its falling edge |
| halt_n | input | 1 | Active-low output inhibit, asynchronous |
| ilim | input | 1 | Current-limit event, active high, synchronous |
| period_len | input | CW | Period length minus one, in cycles |
| dead_len | input | CW | Blanking cycles at the end of each period |
| duty_req | input | CW | Requested on-time in cycles |
| drv_a | output | 1 | Drive A, active high |
| drv_b | output | 1 | Drive B, active high |

## Verification
The cycle-by-cycle properties cover the following: the drives never overlap, a drive follows its phase, the blanking window stays dark, and the drives stay low one cycle after a soft-start hold, a synchronized halt or a current-limit event. Pulse widths, the alternation spacing, the shape of the soft-start ramp and period locking to a resync train span many cycles. Only the bench scenarios can show those, by counting drive-high cycles over whole periods and by timing the rising edges of the drives. The bench scenarios also show the three-edge halt latency measured from the pin, and that the current-limit latch is released at the next boundary.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} pp_phase_e;

  function automatic pp_phase_e other_phase(pp_phase_e p);
    return (p == PH_A) ? PH_B : PH_A;
  endfunction
endpackage

// File: rtl/pp_sync2.sv
module pp_sync2 #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      stab_q <= IDLE;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/pp_period_timer.sv
module pp_period_timer
  import pp_pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          resync_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output pp_phase_e     phase_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  pp_phase_e     phase_q, phase_d;
  logic          prev_q;
  logic          fall;

  // falling edge of the synchronized restart input
  assign fall   = prev_q & ~resync_i;
  assign wrap_o = ~hold_i & ((cnt_q >= period_i) | fall);

  always_comb begin
    cnt_d   = cnt_q + CW'(1);
    phase_d = phase_q;
    if (hold_i) begin
      cnt_d   = '0;
      phase_d = PH_A;
    end else if (wrap_o) begin
      cnt_d   = '0;
      phase_d = other_phase(phase_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_A;
      prev_q  <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      prev_q  <= resync_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
  parameter int          CW      = 8,
  parameter int unsigned SS_STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          step_i,
  output logic [CW-1:0] ramp_o
);
  localparam logic [CW-1:0] FIRST  = CW'(SS_STEP);
  localparam logic [CW:0]   STEP_W = (CW+1)'(SS_STEP);

  logic [CW-1:0] ramp_q, ramp_d;
  logic [CW:0]   sum;
  logic          en;

  assign sum = {1'b0, ramp_q} + STEP_W;
  assign en  = hold_i | step_i;

  always_comb begin
    if (hold_i)      ramp_d = FIRST;
    else if (sum[CW]) ramp_d = '1;
    else              ramp_d = sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ramp_q <= FIRST;
    else if (en) ramp_q <= ramp_d;
  end

  assign ramp_o = ramp_q;
endmodule

// File: rtl/pp_pulse_gate.sv
module pp_pulse_gate
  import pp_pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          halt_i,
  input  logic          ilim_i,
  input  logic          wrap_i,
  input  logic [CW-1:0] cnt_i,
  input  pp_phase_e     phase_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] ramp_i,
  output logic          drv_a_o,
  output logic          drv_b_o
);
  localparam int WW = CW + 1;

  logic [WW-1:0] span, dead_w, lim, min1, eff;
  logic          lat_q, lat_d, lat_en;
  logic          active;
  logic          a_q, b_q, a_d, b_d;

  // width limit from period and blanking window
  assign span   = {1'b0, period_i} + WW'(1);
  assign dead_w = {1'b0, dead_i};
  assign lim    = (dead_w >= span) ? '0 : span - dead_w;
  assign min1   = ({1'b0, duty_i} < {1'b0, ramp_i}) ? {1'b0, duty_i} : {1'b0, ramp_i};
  assign eff    = (min1 < lim) ? min1 : lim;

  // single-pulse current-limit latch, released at a boundary
  assign lat_en = hold_i | wrap_i | ilim_i;
  assign lat_d  = ~hold_i & ~wrap_i & ilim_i;

  assign active = ~hold_i & ~halt_i & ~ilim_i & ~lat_q & ({1'b0, cnt_i} < eff);
  assign a_d    = active & (phase_i == PH_A);
  assign b_d    = active & (phase_i == PH_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign drv_a_o = a_q;
  assign drv_b_o = b_q;
endmodule

// File: rtl/pp_pwm.sv
module pp_pwm
  import pp_pwm_pkg::*;
#(
  parameter int          CW      = 8,
  parameter int unsigned SS_STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_rst_n,
  input  logic          resync_n,
  input  logic          halt_n,
  input  logic          ilim,
  input  logic [CW-1:0] period_len,
  input  logic [CW-1:0] dead_len,
  input  logic [CW-1:0] duty_req,
  output logic          drv_a,
  output logic          drv_b
);
  localparam int NASYNC = 2;

  logic [NASYNC-1:0] raw_n, clean_n;
  logic              resync_q, halt_sync, hold;
  logic [CW-1:0]     cnt_w, ramp_w;
  pp_phase_e         phase_w;
  logic              wrap_w;

  assign raw_n = {halt_n, resync_n};

  for (genvar gi = 0; gi < NASYNC; gi++) begin : g_sync
    pp_sync2 #(.IDLE(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw_n[gi]),
      .q_o  (clean_n[gi])
    );
  end

  assign resync_q  = clean_n[0];
  assign halt_sync = clean_n[1];
  assign hold      = ~ss_rst_n;

  pp_period_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold),
    .resync_i(resync_q),
    .period_i(period_len),
    .cnt_o   (cnt_w),
    .phase_o (phase_w),
    .wrap_o  (wrap_w)
  );

  pp_softstart #(.CW(CW), .SS_STEP(SS_STEP)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .hold_i(hold),
    .step_i(wrap_w),
    .ramp_o(ramp_w)
  );

  pp_pulse_gate #(.CW(CW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold),
    .halt_i  (~halt_sync),
    .ilim_i  (ilim),
    .wrap_i  (wrap_w),
    .cnt_i   (cnt_w),
    .phase_i (phase_w),
    .period_i(period_len),
    .dead_i  (dead_len),
    .duty_i  (duty_req),
    .ramp_i  (ramp_w),
    .drv_a_o (drv_a),
    .drv_b_o (drv_b)
  );
endmodule

// File: rtl/pp_pwm_chk.sv
module pp_pwm_chk
  import pp_pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_rst_n,
  input logic          ilim,
  input logic          drv_a,
  input logic          drv_b,
  input logic          halt_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] period_len,
  input logic [CW-1:0] dead_len,
  input pp_phase_e     phase_q
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_a && drv_b));

  assert_a_follows_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_a |-> $past(phase_q) == PH_A);

  assert_b_follows_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_b |-> $past(phase_q) == PH_B);

  assert_blanking_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, cnt_q} + {1'b0, dead_len}) > {1'b0, period_len}) |=> (!drv_a && !drv_b));

  assert_hold_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rst_n |=> (!drv_a && !drv_b));

  assert_halt_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q |=> (!drv_a && !drv_b));

  assert_ilim_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> (!drv_a && !drv_b));
endmodule

bind pp_pwm pp_pwm_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_rst_n  (ss_rst_n),
  .ilim      (ilim),
  .drv_a     (drv_a),
  .drv_b     (drv_b),
  .halt_q    (halt_sync),
  .cnt_q     (cnt_w),
  .period_len(period_len),
  .dead_len  (dead_len),
  .phase_q   (phase_w)
);

// File: tb/sim_pp_pwm.sv
module sim_pp_pwm;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n, ss_rst_n, resync_n, halt_n, ilim;
  logic [CW-1:0] period_len, dead_len, duty_req;
  logic          drv_a, drv_b;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pp_pwm #(.CW(CW), .SS_STEP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .ss_rst_n(ss_rst_n), .resync_n(resync_n),
    .halt_n(halt_n), .ilim(ilim), .period_len(period_len),
    .dead_len(dead_len), .duty_req(duty_req), .drv_a(drv_a), .drv_b(drv_b)
  );

  // period_len, dead_len, duty_req, expected width per pulse (R2)
  localparam int VEC [0:6][0:3] = '{
    '{19,  4,  8,  8},
    '{19,  4, 30, 16},
    '{ 9,  5,  3,  3},
    '{ 9,  2,  0,  0},
    '{31, 10, 22, 22},
    '{31, 40,  5,  0},
    '{15,  1, 15, 15}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts drive-high samples over n cycles; first: 1=A first, 2=B first, 0=none
  task automatic measure(input int n, output int na, output int nb,
                         output int nboth, output int first);
    na = 0; nb = 0; nboth = 0; first = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (drv_a) na++;
      if (drv_b) nb++;
      if (drv_a && drv_b) nboth++;
      if (first == 0 && drv_a) first = 1;
      if (first == 0 && drv_b) first = 2;
    end
  endtask

  task automatic wait_rise(input bit sel_b, output int n);
    bit prev, cur;
    prev = sel_b ? drv_b : drv_a;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      tick();
      n++;
      cur = sel_b ? drv_b : drv_a;
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  task automatic setcfg(input int p, input int d, input int u);
    period_len = CW'(p);
    dead_len   = CW'(d);
    duty_req   = CW'(u);
  endtask

  initial begin
    int na, nb, nboth, first, d0, d1, d2;
    rst_n = 1'b0; ss_rst_n = 1'b0; resync_n = 1'b1; halt_n = 1'b1; ilim = 1'b0;
    setcfg(19, 4, 200);

    repeat (3) tick();
    chk("R8 reset drives low", int'(drv_a) + int'(drv_b), 0);
    rst_n = 1'b1;

    // R4: held soft-start keeps drives dark even with large duty
    measure(12, na, nb, nboth, first);
    chk("R4 hold dark", na + nb, 0);

    // R4: release, ramp opens 1,2,3,4 cycles, A first
    ss_rst_n = 1'b1;
    measure(40, na, nb, nboth, first);
    chk("R4 first pulse A width", na, 1);
    chk("R4 first pulse B width", nb, 2);
    chk("R4 first pulse on A", first, 1);
    measure(40, na, nb, nboth, first);
    chk("R4 ramp A width", na, 3);
    chk("R4 ramp B width", nb, 4);

    repeat (270 * 20) tick();

    // R2/R3: table of configurations, saturated ramp
    for (int v = 0; v < 7; v++) begin
      setcfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      repeat (100) tick();
      measure(4 * (VEC[v][0] + 1), na, nb, nboth, first);
      chk($sformatf("R2 vec%0d A width", v), na, 2 * VEC[v][3]);
      chk($sformatf("R2 vec%0d B width", v), nb, 2 * VEC[v][3]);
      chk($sformatf("R3 vec%0d overlap", v), nboth, 0);
    end

    // R1: alternation spacing
    setcfg(19, 4, 8);
    repeat (60) tick();
    wait_rise(1'b0, d0);
    wait_rise(1'b1, d1);
    wait_rise(1'b0, d2);
    chk("R1 A to B spacing", d1, 20);
    chk("R1 A period", d1 + d2, 40);

    // R5: resync train every 15 cycles locks period
    fork
      begin
        for (int k = 0; k < 14; k++) begin
          resync_n = 1'b0; repeat (2) tick();
          resync_n = 1'b1; repeat (13) tick();
        end
      end
      begin
        repeat (60) tick();
        wait_rise(1'b0, d0);
        wait_rise(1'b0, d1);
      end
    join
    chk("R5 locked A period", d1, 30);

    // R5: a held low level does not keep restarting
    resync_n = 1'b0;
    repeat (60) tick();
    wait_rise(1'b0, d0);
    wait_rise(1'b0, d1);
    chk("R5 held low free-run period", d1, 40);
    resync_n = 1'b1;

    // R6: halt cuts a pulse in progress
    setcfg(19, 4, 16);
    repeat (60) tick();
    wait_rise(1'b0, d0);
    halt_n = 1'b0;
    repeat (3) tick();
    chk("R6 halt third edge", int'(drv_a) + int'(drv_b), 0);
    measure(80, na, nb, nboth, first);
    chk("R6 halt held dark", na + nb, 0);
    halt_n = 1'b1;
    repeat (60) tick();
    measure(80, na, nb, nboth, first);
    chk("R6 recovery A width", na, 32);
    chk("R6 recovery B width", nb, 32);

    // R7: current-limit cuts A pulse, B next period is normal
    wait_rise(1'b0, d0);
    na = 1; nb = 0;
    ilim = 1'b1;
    for (int i = 1; i < 40; i++) begin
      tick();
      if (i == 1) ilim = 1'b0;
      if (drv_a) na++;
      if (drv_b) nb++;
    end
    chk("R7 limited A width", na, 1);
    chk("R7 B after release", nb, 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule